// File: doc/BRIEF.md
# CAN Bus-Off Recovery Controller

This block tracks whether a CAN protocol controller has been disconnected from the bus after too many errors, and it sequences the return to normal operation. When the error confinement logic raises a bus-off trigger, the block marks the node as off the bus and flags an error. It also turns off the bus drivers so that the outputs float, and it forces the reset-request control bit high.

Recovery starts only after the CPU writes the reset-request bit low. From then on the block watches the received bit stream, one sample per bit-time strobe. It counts bus-free occurrences, each made of 11 recessive samples in a row. After the 128th occurrence it returns the node to bus-on and clears the error flag. In that same step it sends a one-cycle clear to the transmit and receive error counters and enables the drivers again. If the CPU sets reset-request again during the wait, the count is dropped and starts over after the next clear.

Top module: `can_busoff_recovery`

## Requirements
- R1: One cycle after `busoff_trig_i` is sampled high, `bus_off_o`, `err_o` and `rst_req_o` are all 1. The trigger wins over a CPU write and over a recovery ending in the same cycle.
- R2: `rst_req_o` goes low only when the CPU writes 0 (`cpu_wr_i`=1, `cpu_wdata_i`=0). If a CPU clear and a trigger come in the same cycle, the bit stays 1.
- R3: A bus-free occurrence is 11 consecutive samples with `bit_stb_i`=1 and `rx_rec_i`=1. A strobed dominant sample (`rx_rec_i`=0) restarts the run. Occurrences are counted only while `bus_off_o`=1 and `rst_req_o`=0.
- R4: On the 128th counted occurrence, `bus_off_o` and `err_o` both fall one cycle later, in the same cycle. `cnt_clr_o` is 1 for exactly that one cycle.
- R5: `drv_en_o` is 0 whenever `bus_off_o` is 1, and it is 1 in bus-on.
- R6: A CPU write of 1 during the wait leaves the block in bus-off with `rst_req_o`=1, also when it comes in the cycle of the 128th occurrence. After the next clear, counting restarts from zero.
- R7: After reset: `bus_off_o`=0, `err_o`=0, `rst_req_o`=0, `drv_en_o`=1, `cnt_clr_o`=0, and the occurrence count is zero.
- R8: In bus-on, CPU writes set and clear `rst_req_o` and leave `bus_off_o`, `err_o` and `drv_en_o` unchanged.
- R9: Samples in cycles with `bit_stb_i`=0 neither advance nor restart a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busoff_trig_i | input | 1 | Bus-off entry pulse from error confinement |
| bit_stb_i | input | 1 | One-cycle strobe per bit time |
| rx_rec_i | input | 1 | Bus sample, 1 = recessive |
| cpu_wr_i | input | 1 | CPU write strobe for the reset-request bit |
| cpu_wdata_i | input | 1 | Value written to reset-request |
| bus_off_o | output | 1 | Bus status, 1 = bus-off |
| err_o | output | 1 | Error status, 1 = error |
| rst_req_o | output | 1 | Reset-request bit |
| cnt_clr_o | output | 1 | One-cycle clear to both error counters |
| drv_en_o | output | 1 | Bus driver enable, 0 = outputs float |

## Verification
Two events can fall in the same cycle: the end of recovery on the 128th occurrence, and either a new bus-off trigger or a CPU write of 1 to reset-request. The bench provokes each case by sending 127 occurrences and 10 recessive bits, then putting the trigger or the CPU write on the final recessive strobe. The block must stay in bus-off with reset-request high and no counter clear. A CPU clear that arrives in the same cycle as a trigger is judged the same way. After each case, a full recovery has to run from zero again.

// File: rtl/can_bor_pkg.sv
package can_bor_pkg;
  typedef enum logic [1:0] {
    ST_ON   = 2'd0,  // bus-on
    ST_HOLD = 2'd1,  // bus-off, reset-request held
    ST_WAIT = 2'd2   // bus-off, counting bus-free occurrences
  } bor_state_e;
endpackage

// File: rtl/can_bor_idle_det.sv
module can_bor_idle_det #(
  parameter int unsigned IDLE_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic stb_i,
  input  logic rec_i,
  output logic free_o
);
  localparam int unsigned RW = $clog2(IDLE_BITS);
  localparam logic [RW-1:0] RUN_LAST = RW'(IDLE_BITS - 1);

  logic [RW-1:0] run_q;

  assign free_o = !clr_i && stb_i && rec_i && (run_q == RUN_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          run_q <= '0;
    else if (clr_i)       run_q <= '0;
    else if (stb_i) begin
      if (!rec_i || run_q == RUN_LAST) run_q <= '0;
      else                             run_q <= run_q + 1'b1;
    end
  end

  // R3
  run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_LAST);

  // R9
  run_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stb_i && !clr_i) |=> $stable(run_q));
endmodule

// File: rtl/can_bor_occ_cnt.sv
module can_bor_occ_cnt #(
  parameter int unsigned OCC_TARGET = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(OCC_TARGET);
  localparam logic [CW-1:0] CNT_LAST = CW'(OCC_TARGET - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = !clr_i && inc_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i || done_o)        cnt_q <= '0;
    else if (inc_i)                  cnt_q <= cnt_q + 1'b1;
  end

  // R3
  occ_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);

  // R6
  occ_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/can_bor_ctrl.sv
module can_bor_ctrl
  import can_bor_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busoff_trig_i,
  input  logic cpu_wr_i,
  input  logic cpu_wdata_i,
  input  logic done_i,
  output logic wait_o,
  output logic bus_off_o,
  output logic err_o,
  output logic rst_req_o,
  output logic drv_en_o,
  output logic cnt_clr_o
);
  bor_state_e state_q, state_d;
  logic bus_off_q, bus_off_d, err_q, err_d, req_q, req_d;
  logic drv_q, drv_d, clr_q, clr_d;
  logic cpu_set, cpu_clr;

  assign cpu_set = cpu_wr_i && cpu_wdata_i;
  assign cpu_clr = cpu_wr_i && !cpu_wdata_i;
  // counting is live only when nothing else preempts the wait this cycle
  assign wait_o  = (state_q == ST_WAIT) && !cpu_set && !busoff_trig_i;

  always_comb begin
    state_d   = state_q;
    bus_off_d = bus_off_q;
    err_d     = err_q;
    drv_d     = drv_q;
    clr_d     = 1'b0;
    if (busoff_trig_i || cpu_set) req_d = 1'b1;
    else if (cpu_clr)             req_d = 1'b0;
    else                          req_d = req_q;

    if (busoff_trig_i) begin
      state_d   = ST_HOLD;
      bus_off_d = 1'b1;
      err_d     = 1'b1;
      drv_d     = 1'b0;
    end else begin
      unique case (state_q)
        ST_ON:   state_d = ST_ON;
        ST_HOLD: if (cpu_clr) state_d = ST_WAIT;
        ST_WAIT: begin
          if (cpu_set) state_d = ST_HOLD;
          else if (done_i) begin
            state_d   = ST_ON;
            bus_off_d = 1'b0;
            err_d     = 1'b0;
            drv_d     = 1'b1;
            clr_d     = 1'b1;
          end
        end
        default: state_d = ST_ON;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_ON;
      bus_off_q <= 1'b0;
      err_q     <= 1'b0;
      req_q     <= 1'b0;
      drv_q     <= 1'b1;
      clr_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      bus_off_q <= bus_off_d;
      err_q     <= err_d;
      req_q     <= req_d;
      drv_q     <= drv_d;
      clr_q     <= clr_d;
    end
  end

  assign bus_off_o = bus_off_q;
  assign err_o     = err_q;
  assign rst_req_o = req_q;
  assign drv_en_o  = drv_q;
  assign cnt_clr_o = clr_q;

  // R1
  entry_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busoff_trig_i |=> (bus_off_o && err_o && rst_req_o && !cnt_clr_o));

  // R2
  req_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o && !cpu_clr) |=> rst_req_o);

  // R4
  restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_off_o) |-> ($fell(err_o) && cnt_clr_o && drv_en_o));

  // R4
  clr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_o |=> !cnt_clr_o);

  // R5
  drv_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_off_o |-> !drv_en_o);

  // R6
  abandon_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_off_o && cpu_set) |=> (bus_off_o && rst_req_o));
endmodule

// File: rtl/can_busoff_recovery.sv
module can_busoff_recovery #(
  parameter int unsigned IDLE_BITS  = 11,
  parameter int unsigned OCC_TARGET = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busoff_trig_i,
  input  logic bit_stb_i,
  input  logic rx_rec_i,
  input  logic cpu_wr_i,
  input  logic cpu_wdata_i,
  output logic bus_off_o,
  output logic err_o,
  output logic rst_req_o,
  output logic cnt_clr_o,
  output logic drv_en_o
);
  logic wait_w, free_w, done_w;

  can_bor_idle_det #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!wait_w),
    .stb_i  (bit_stb_i),
    .rec_i  (rx_rec_i),
    .free_o (free_w)
  );

  can_bor_occ_cnt #(.OCC_TARGET(OCC_TARGET)) u_occ (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!wait_w),
    .inc_i  (free_w),
    .done_o (done_w)
  );

  can_bor_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .busoff_trig_i (busoff_trig_i),
    .cpu_wr_i      (cpu_wr_i),
    .cpu_wdata_i   (cpu_wdata_i),
    .done_i        (done_w),
    .wait_o        (wait_w),
    .bus_off_o     (bus_off_o),
    .err_o         (err_o),
    .rst_req_o     (rst_req_o),
    .drv_en_o      (drv_en_o),
    .cnt_clr_o     (cnt_clr_o)
  );
endmodule

// File: tb/can_busoff_recovery_test.sv
module can_busoff_recovery_test;
  localparam int CLK_P = 10;
  localparam int WDOG  = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0, stb = 1'b0, rec = 1'b0, wr = 1'b0, wd = 1'b0;
  logic bus_off, err, req, cclr, drv;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  // expectation encoding: {bus_off, err, rst_req, drv_en, cnt_clr}
  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  can_busoff_recovery uut (
    .clk_i(clk), .rst_ni(rst_n), .busoff_trig_i(trig), .bit_stb_i(stb),
    .rx_rec_i(rec), .cpu_wr_i(wr), .cpu_wdata_i(wd), .bus_off_o(bus_off),
    .err_o(err), .rst_req_o(req), .cnt_clr_o(cclr), .drv_en_o(drv)
  );

  // monitor: compares a quarter period after the edge that produced the result
  initial forever begin
    @(posedge clk);
    #(CLK_P/4);
    if (exp_q.size() > 0) begin
      logic [4:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {bus_off, err, req, drv, cclr};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s actual=%b expected=%b", t, a, e);
      end
    end
  end

  task automatic step(input logic s, input logic r, input logic t,
                      input logic w, input logic d);
    @(negedge clk);
    stb = s; rec = r; trig = t; wr = w; wd = d;
  endtask

  task automatic step_chk(input logic s, input logic r, input logic t,
                          input logic w, input logic d,
                          input logic [4:0] e, input string tg);
    step(s, r, t, w, d);
    exp_q.push_back(e);
    tag_q.push_back(tg);
  endtask

  // gap cycles drive a dominant level with no strobe (R9)
  task automatic send_bit(input logic r);
    step(1'b1, r, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic send_occ(input int n);
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 11; b++) send_bit(1'b1);
  endtask

  task automatic idle_chk(input logic [4:0] e, input string tg);
    step_chk(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, e, tg);
  endtask

  // 127 occurrences + 10 bits, last bit carries the given side inputs
  task automatic run_to_end(input logic t, input logic w, input logic d,
                            input logic [4:0] e, input string tg);
    send_occ(127);
    for (int b = 0; b < 10; b++) send_bit(1'b1);
    step_chk(1'b1, 1'b1, t, w, d, e, tg);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic enter_and_clear();
    step_chk(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'b11100, "R1 entry");
    step_chk(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'b11000, "R2 cpu clear");
  endtask

  task automatic finish_run();
    wait (exp_q.size() == 0);
    @(negedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WDOG; c++) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_chk(5'b00010, "R7 reset state");

    // R8: CPU access in bus-on
    step_chk(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'b00110, "R8 set in bus-on");
    step_chk(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'b00010, "R8 clear in bus-on");

    // R1 / R5 entry, R3 no counting while request held
    step_chk(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'b11100, "R1 R5 entry");
    send_occ(130);
    idle_chk(5'b11100, "R3 no count while request high");
    step_chk(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 5'b11100, "R2 clear vs trigger");
    step_chk(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'b11000, "R2 cpu clear");

    // R3 dominant restart, R9 unstrobed samples ignored
    send_occ(127);
    for (int b = 0; b < 10; b++) send_bit(1'b1);
    send_bit(1'b0);
    for (int b = 0; b < 10; b++) send_bit(1'b1);
    idle_chk(5'b11000, "R3 R9 run restarted by dominant");
    step_chk(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00011, "R4 R5 recovery");
    idle_chk(5'b00010, "R4 clear is one cycle");

    // R6 abandon and restart from zero
    enter_and_clear();
    send_occ(60);
    step_chk(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'b11100, "R6 set during wait");
    send_occ(100);
    idle_chk(5'b11100, "R6 held after abandon");
    step_chk(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'b11000, "R6 clear again");
    send_occ(127);
    idle_chk(5'b11000, "R6 count restarted from zero");
    for (int b = 0; b < 10; b++) send_bit(1'b1);
    step_chk(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00011, "R6 R4 recovery after restart");
    idle_chk(5'b00010, "R4 back to bus-on");

    // collision: trigger on the final occurrence
    enter_and_clear();
    run_to_end(1'b1, 1'b0, 1'b0, 5'b11100, "R1 trigger beats recovery");
    idle_chk(5'b11100, "R1 stays bus-off");

    // collision: CPU set on the final occurrence
    step_chk(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'b11000, "R2 cpu clear");
    run_to_end(1'b0, 1'b1, 1'b1, 5'b11100, "R6 set beats recovery");

    step_chk(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'b11000, "R2 cpu clear");
    run_to_end(1'b0, 1'b0, 1'b0, 5'b00011, "R4 full recovery after collisions");
    idle_chk(5'b00010, "R5 drivers enabled");

    finish_run();
  end
endmodule